// File: doc/BRIEF.md
# Per-Core Interrupt Priority Arbiter

This block looks at a bank of interrupt sources and, for each processor core, picks the most urgent source that may interrupt that core. Every source has an enable bit and a pending bit, kept separately for each core, together with a set of target-core bits and one 8-bit priority. A smaller priority value is more urgent. For each core, the block reports the identifier of its best candidate, or the spurious code 1023 when there is none. It also drives a request line that tells the core to take an interrupt.

Each core has a priority mask and a running priority. A candidate is reported only when its priority is strictly below the core's mask. The request line rises only when that priority is also strictly below the running priority. When the running priority blocks the request, the candidate's identifier is still reported. A two-bit group enable for the whole block and a two-bit group enable for each core gate everything. If all bits of either one are clear, that core shows no candidate and its request stays low. Register access, acknowledge, end of interrupt and security banking belong to surrounding logic; this block sees their results as plain inputs. The arbitration is combinational, and both outputs are registered.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Source i is a candidate for core c only when its enable bit `src_en[c*NUM_SRC+i]` and its pending bit `src_pend[c*NUM_SRC+i]` are both set, and, for i of 32 or more, its target bit `src_tgt[i*NUM_CORE+c]` is set.
- R2: Sources 0 to 31 are private to each core. They are candidates for a core whatever their target bits are.
- R3: The priority of source i is `src_prio[i*8 +: 8]`, and the lowest value among the candidates wins.
- R4: When two candidates have the same priority, the one with the lower identifier wins.
- R5: When a core has no candidate, its `hp_id` field reads 1023 and its request is low.
- R6: The winner is reported only when its priority is strictly less than the core's mask `core_pmask[c*8 +: 8]`. When the priority equals or exceeds the mask, `hp_id` reads 1023 and the request is low.
- R7: The request `irq_req[c]` is high only when the reported winner's priority is strictly less than the 9-bit running priority `core_run_prio[c*9 +: 9]`, where 0x100 means idle. When the request is blocked by the running priority, the winner's identifier is still shown in `hp_id`.
- R8: When `dist_grp_en` is 00, or the core's `core_grp_en[c*2 +: 2]` is 00, that core's `hp_id` is 1023 and its request is low.
- R9: After reset, every `hp_id` field is 1023 and every request is low. A change on any input appears on the outputs after exactly one rising clock edge.
- R10: Each core's result depends only on its own enable, pending, target, mask, running-priority and group-enable inputs, together with the shared priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dist_grp_en | input | 2 | Group enables for the whole block |
| core_grp_en | input | 2*NUM_CORE | Group enables for each core |
| src_en | input | NUM_CORE*NUM_SRC | Enable bit of each source, one bank per core |
| src_pend | input | NUM_CORE*NUM_SRC | Pending bit of each source, one bank per core |
| src_tgt | input | NUM_SRC*NUM_CORE | Target-core bits of each source |
| src_prio | input | 8*NUM_SRC | Priority of each source |
| core_pmask | input | 8*NUM_CORE | Priority mask of each core |
| core_run_prio | input | 9*NUM_CORE | Running priority of each core (0x100 means idle) |
| hp_id | output | 10*NUM_CORE | Highest-pending identifier of each core, 1023 for none |
| irq_req | output | NUM_CORE | Interrupt request line of each core |

## Verification
The hardest situations to reach are the exact boundaries: a winner whose priority equals the mask, a winner whose priority equals the running priority, and a tie between sources that sit in different halves of the comparison tree. Directed steps set up each of these with one or two sources, then move the mask or the running priority by one step on either side of the boundary. A long sweep follows. It draws priorities from a narrow range so that ties are frequent, fills the pending and target maps sparsely, and sets the masks, running priorities and group enables at random. After every step, both cores are compared against a plain search loop in the bench.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int PRIO_W      = 8;
   localparam int RUN_W       = PRIO_W + 1;
   localparam int ID_W        = 10;
   localparam int PRIVATE_IDS = 32;
   localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
   localparam logic [RUN_W-1:0] IDLE_PRIO   = 9'h100;

   typedef struct packed {
      logic [RUN_W-1:0] prio;
      logic [ID_W-1:0]  id;
   } cand_t;
endpackage

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic [NUM_SRC-1:0]        valid,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output cand_t                     win
);
   localparam int LEAVES = 1 << $clog2(NUM_SRC);
   localparam int NODES  = 2 * LEAVES - 1;

   cand_t node [NODES];

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < NUM_SRC) begin : g_real
         assign node[LEAVES-1+i].prio = valid[i] ? {1'b0, prio[i*PRIO_W +: PRIO_W]} : IDLE_PRIO;
         assign node[LEAVES-1+i].id   = ID_W'(i);
      end else begin : g_pad
         assign node[LEAVES-1+i].prio = IDLE_PRIO;
         assign node[LEAVES-1+i].id   = ID_W'(0);
      end
   end

   // Left subtree holds lower IDs; right wins only when strictly more urgent.
   for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
      assign node[k] = (node[2*k+2].prio < node[2*k+1].prio) ? node[2*k+2] : node[2*k+1];
   end

   assign win = node[0];
endmodule

// File: rtl/irq_arb_core.sv
module irq_arb_core
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                dist_grp_en,
   input  logic [1:0]                core_grp_en,
   input  logic [NUM_SRC-1:0]        en,
   input  logic [NUM_SRC-1:0]        pend,
   input  logic [NUM_SRC-1:0]        tgt,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]         pmask,
   input  logic [RUN_W-1:0]          run_prio,
   output logic [ID_W-1:0]           hp_id,
   output logic                      req
);
   logic [NUM_SRC-1:0] cand;
   cand_t              win;
   logic               gate_on;
   logic               shown;
   logic               fire;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
      localparam bit PRIV = (i < PRIVATE_IDS);
      assign cand[i] = en[i] & pend[i] & (tgt[i] | PRIV);
   end

   irq_arb_tree #(.NUM_SRC(NUM_SRC)) u_tree (
      .valid (cand),
      .prio  (prio),
      .win   (win)
   );

   always_comb begin
      gate_on = (|dist_grp_en) & (|core_grp_en);
      shown   = gate_on && (win.prio < {1'b0, pmask});
      fire    = shown && (win.prio < run_prio);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp_id <= SPURIOUS_ID;
         req   <= 1'b0;
      end else begin
         hp_id <= shown ? win.id : SPURIOUS_ID;
         req   <= fire;
      end
   end

   p_win_is_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (win.prio != IDLE_PRIO) |-> cand[win.id[$clog2(NUM_SRC)-1:0]]);
   p_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cand == '0) |=> (hp_id == SPURIOUS_ID && !req));
   p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_id != SPURIOUS_ID) |-> ($past(win.prio) < {1'b0, $past(pmask)}));
   p_req_has_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (hp_id != SPURIOUS_ID));
   p_run_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (win.prio >= run_prio) |=> !req);
   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dist_grp_en == 2'b00 || core_grp_en == 2'b00) |=> (hp_id == SPURIOUS_ID && !req));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC  = 64,
   parameter int NUM_CORE = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   dist_grp_en,
   input  logic [2*NUM_CORE-1:0]        core_grp_en,
   input  logic [NUM_CORE*NUM_SRC-1:0]  src_en,
   input  logic [NUM_CORE*NUM_SRC-1:0]  src_pend,
   input  logic [NUM_SRC*NUM_CORE-1:0]  src_tgt,
   input  logic [PRIO_W*NUM_SRC-1:0]    src_prio,
   input  logic [PRIO_W*NUM_CORE-1:0]   core_pmask,
   input  logic [RUN_W*NUM_CORE-1:0]    core_run_prio,
   output logic [ID_W*NUM_CORE-1:0]     hp_id,
   output logic [NUM_CORE-1:0]          irq_req
);
   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 992) begin : g_bad_src
      $error("NUM_SRC must be a multiple of 32 between 32 and 992");
   end
   if (NUM_CORE < 1 || NUM_CORE > 8) begin : g_bad_core
      $error("NUM_CORE must be between 1 and 8");
   end

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      logic [NUM_SRC-1:0] tgt_col;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_col
         assign tgt_col[i] = src_tgt[i*NUM_CORE+c];
      end

      irq_arb_core #(.NUM_SRC(NUM_SRC)) u_core (
         .clk         (clk),
         .rst_n       (rst_n),
         .dist_grp_en (dist_grp_en),
         .core_grp_en (core_grp_en[c*2 +: 2]),
         .en          (src_en[c*NUM_SRC +: NUM_SRC]),
         .pend        (src_pend[c*NUM_SRC +: NUM_SRC]),
         .tgt         (tgt_col),
         .prio        (src_prio),
         .pmask       (core_pmask[c*PRIO_W +: PRIO_W]),
         .run_prio    (core_run_prio[c*RUN_W +: RUN_W]),
         .hp_id       (hp_id[c*ID_W +: ID_W]),
         .req         (irq_req[c])
      );
   end
endmodule

// File: tb/irq_prio_arbiter_test.sv
`timescale 1ns/1ps
module irq_prio_arbiter_test;
   localparam int NS = 64;
   localparam int NC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]      dist_grp_en = 2'b00;
   logic [2*NC-1:0] core_grp_en = '0;
   logic [NC*NS-1:0] src_en = '0;
   logic [NC*NS-1:0] src_pend = '0;
   logic [NS*NC-1:0] src_tgt = '0;
   logic [8*NS-1:0]  src_prio = '0;
   logic [8*NC-1:0]  core_pmask = '0;
   logic [9*NC-1:0]  core_run_prio = '0;
   logic [10*NC-1:0] hp_id;
   logic [NC-1:0]    irq_req;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   irq_prio_arbiter #(.NUM_SRC(NS), .NUM_CORE(NC)) uut (
      .clk(clk), .rst_n(rst_n), .dist_grp_en(dist_grp_en), .core_grp_en(core_grp_en),
      .src_en(src_en), .src_pend(src_pend), .src_tgt(src_tgt), .src_prio(src_prio),
      .core_pmask(core_pmask), .core_run_prio(core_run_prio),
      .hp_id(hp_id), .irq_req(irq_req)
   );

   // Plain search per core, written from the requirements.
   task automatic model(input int c, output logic [9:0] id, output logic rq);
      int best_p = 256;
      int best_i = 1023;
      for (int i = 0; i < NS; i++) begin
         if (src_en[c*NS+i] && src_pend[c*NS+i] && (i < 32 || src_tgt[i*NC+c])) begin
            if (int'(src_prio[i*8 +: 8]) < best_p) begin
               best_p = int'(src_prio[i*8 +: 8]);
               best_i = i;
            end
         end
      end
      id = 10'd1023;
      rq = 1'b0;
      if (dist_grp_en != 0 && core_grp_en[c*2 +: 2] != 0 && best_p < int'(core_pmask[c*8 +: 8])) begin
         id = 10'(best_i);
         rq = (best_p < int'(core_run_prio[c*9 +: 9]));
      end
   endtask

   task automatic chk(input string tag, input int c, input logic [9:0] eid, input logic erq);
      checks++;
      if (hp_id[c*10 +: 10] !== eid || irq_req[c] !== erq) begin
         errors++;
         $display("FAIL %s core%0d: id=%0d req=%b expected id=%0d req=%b",
                  tag, c, hp_id[c*10 +: 10], irq_req[c], eid, erq);
      end
   endtask

   task automatic chk_model(input string tag);
      logic [9:0] eid;
      logic erq;
      for (int c = 0; c < NC; c++) begin
         model(c, eid, erq);
         chk(tag, c, eid, erq);
      end
   endtask

   // Inputs change at a falling edge; outputs are read at the next falling edge.
   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_all();
      src_en = '0; src_pend = '0; src_tgt = '0; src_prio = '0;
   endtask

   task automatic put(input int c, input int i, input int p);
      src_en[c*NS+i] = 1'b1;
      src_pend[c*NS+i] = 1'b1;
      src_prio[i*8 +: 8] = 8'(p);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      chk("R9 reset", 0, 10'd1023, 1'b0);
      chk("R9 reset", 1, 10'd1023, 1'b0);
      rst_n = 1'b1;
      dist_grp_en = 2'b01;
      core_grp_en = 4'b0101;
      core_pmask = {8'hFF, 8'hFF};
      core_run_prio = {9'h100, 9'h100};
      step();

      // R5: nothing pending
      chk("R5 empty", 0, 10'd1023, 1'b0);
      chk("R5 empty", 1, 10'd1023, 1'b0);

      // R1: shared source 40 targeted at core 1 only, enabled in both banks
      put(0, 40, 8'h30); put(1, 40, 8'h30);
      src_tgt[40*NC+1] = 1'b1;
      step();
      chk("R1 target", 0, 10'd1023, 1'b0);
      chk("R1 target", 1, 10'd40, 1'b1);
      src_pend[1*NS+40] = 1'b0;
      step();
      chk("R1 not pending", 1, 10'd1023, 1'b0);
      src_pend[1*NS+40] = 1'b1; src_en[1*NS+40] = 1'b0;
      step();
      chk("R1 not enabled", 1, 10'd1023, 1'b0);

      // R2: private source with no target bits
      clear_all();
      put(0, 5, 8'h50);
      step();
      chk("R2 private", 0, 10'd5, 1'b1);
      chk("R10 other core idle", 1, 10'd1023, 1'b0);

      // R3: lower value wins
      clear_all();
      put(0, 33, 8'h40); put(0, 50, 8'h10);
      src_tgt[33*NC+0] = 1'b1; src_tgt[50*NC+0] = 1'b1;
      step();
      chk("R3 urgency", 0, 10'd50, 1'b1);

      // R4: tie across tree halves and within a pair
      clear_all();
      put(0, 34, 8'h20); put(0, 60, 8'h20); put(0, 3, 8'h21);
      src_tgt[34*NC+0] = 1'b1; src_tgt[60*NC+0] = 1'b1;
      step();
      chk("R4 tie", 0, 10'd34, 1'b1);
      put(0, 2, 8'h20); put(0, 1, 8'h20);
      step();
      chk("R4 tie low id", 0, 10'd1, 1'b1);

      // R6: mask boundary (best is 0x20)
      core_pmask[7:0] = 8'h20;
      step();
      chk("R6 mask equal", 0, 10'd1023, 1'b0);
      core_pmask[7:0] = 8'h21;
      step();
      chk("R6 mask above", 0, 10'd1, 1'b1);
      core_pmask[7:0] = 8'h00;
      step();
      chk("R6 mask zero", 0, 10'd1023, 1'b0);
      core_pmask[7:0] = 8'hFF;

      // R7: running-priority boundary
      core_run_prio[8:0] = 9'h020;
      step();
      chk("R7 run equal", 0, 10'd1, 1'b0);
      core_run_prio[8:0] = 9'h021;
      step();
      chk("R7 run above", 0, 10'd1, 1'b1);
      core_run_prio[8:0] = 9'h000;
      step();
      chk("R7 run zero", 0, 10'd1, 1'b0);
      core_run_prio[8:0] = 9'h100;

      // R8: gating
      dist_grp_en = 2'b00;
      step();
      chk("R8 dist off", 0, 10'd1023, 1'b0);
      dist_grp_en = 2'b10;
      step();
      chk("R8 dist grp1", 0, 10'd1, 1'b1);
      core_grp_en[1:0] = 2'b00;
      step();
      chk("R8 core off", 0, 10'd1023, 1'b0);
      core_grp_en[1:0] = 2'b10;
      step();
      chk("R8 core grp1", 0, 10'd1, 1'b1);

      // R9: one edge of latency
      src_pend[0*NS+1] = 1'b0;
      #1;
      chk("R9 before edge", 0, 10'd1, 1'b1);
      step();
      chk("R9 after edge", 0, 10'd2, 1'b1);

      // R10: independent banks for the same private ID
      clear_all();
      put(0, 7, 8'h10); put(1, 9, 8'h10);
      core_run_prio = {9'h100, 9'h005};
      step();
      chk("R10 core0", 0, 10'd7, 1'b0);
      chk("R10 core1", 1, 10'd9, 1'b1);

      // Sweep against the search loop (R1 to R8)
      for (int v = 0; v < 1500; v++) begin
         for (int b = 0; b < NC*NS; b++) begin
            src_en[b]   = ($urandom % 3) != 0;
            src_pend[b] = ($urandom % 8) == 0;
         end
         for (int b = 0; b < NS*NC; b++) src_tgt[b] = ($urandom % 2) == 0;
         for (int i = 0; i < NS; i++) src_prio[i*8 +: 8] = 8'(($urandom % 2) ? ($urandom % 12) : $urandom);
         for (int c = 0; c < NC; c++) begin
            core_pmask[c*8 +: 8]    = 8'(($urandom % 2) ? ($urandom % 14) : $urandom);
            core_run_prio[c*9 +: 9] = 9'(($urandom % 4 == 0) ? 256 : ($urandom % 16));
            core_grp_en[c*2 +: 2]   = 2'(($urandom % 6 == 0) ? 0 : ($urandom % 3) + 1);
         end
         dist_grp_en = 2'(($urandom % 8 == 0) ? 0 : ($urandom % 3) + 1);
         step();
         chk_model("R1-sweep R3 R4 R6 R7 R8");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule